// File: doc/BRIEF.md
# Header-Inserting Round-Robin Stream Merger

The block merges four 32-bit AXI4-Stream sources onto one AXI4-Stream output. It works in packets. For each source in turn, it first emits a computed 32-bit routing header. It then forwards a fixed-length burst of payload words taken from that source alone. A downstream switch reads the header to steer the burst, so the header's field layout and parity are fixed by the receiver.

A one-cycle start pulse launches a run. The run covers a requested number of rounds, and each round visits sources 0 to 3 once. A done flag reports that the last word of the run has left the block. The output holds a single registered word, and it honours backpressure without losing or repeating data.

Top module: `pkt_hdr_merge`

## Requirements
- R1: In every header, bits [4:0] equal the packet ID that the ID table holds for the source being served (table entry i sits at parameter bits [5i+4:5i]), and bits [11:5] are zero.
- R2: In every header, bits [14:12] equal the configured packet type (default 0), and bit 15 is zero.
- R3: In every header, bits [20:16] and [27:21] are all ones, and bits [30:28] are zero.
- R4: Header bit 31 is 1 exactly when bits [30:0] hold an even number of ones, so each header word has odd parity.
- R5: Each packet is one header followed by exactly 8 payload words. The payload words are accepted from the selected source only, and their data and TKEEP are forwarded unchanged and in order.
- R6: Sources are served in the order 0, 1, 2, 3, and this round repeats as many times as the iteration count sampled at start.
- R7: Header words carry TKEEP 4'hF and TLAST low. TLAST is high on the 8th payload word of each packet and on no other word.
- R8: A source sees TREADY only while its payload is due and the output register is free, and at most one source sees it at a time. While the output is valid and not ready, the presented word (data, TKEEP, TLAST) stays unchanged.
- R9: done_o rises only after the last word of the run has been accepted, and it stays high until the next start, which clears it. A start with an iteration count of zero sets done_o on the next cycle and emits no words.
- R10: After reset, the output is not valid, no source sees TREADY, and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run launch pulse, taken only when idle |
| iter_count_i | input | CNT_W | Number of rounds over all sources |
| s_tdata_i | input | NUM_IN*32 | Source data, source i at bits [32i+31:32i] |
| s_tkeep_i | input | NUM_IN*4 | Source byte enables |
| s_tvalid_i | input | NUM_IN | Source valid flags |
| s_tready_o | output | NUM_IN | Source ready flags |
| m_tdata_o | output | 32 | Merged stream data |
| m_tkeep_o | output | 4 | Merged stream byte enables |
| m_tlast_o | output | 1 | End of packet marker |
| m_tvalid_o | output | 1 | Merged stream valid |
| m_tready_i | input | 1 | Merged stream ready |
| done_o | output | 1 | Run complete, sticky until next start |

## Verification
The main collision is between loading a new word into the output register and draining the current one. Both happen in the same cycle whenever the sink is ready while a source is valid. A wrong priority there drops or repeats a word at packet and round boundaries. The bench provokes this by combining sink ready patterns (always, three of four cycles, alternate cycles, held low) with gappy source valid patterns. It judges the result by comparing the full captured stream, word by word, against a stream model built from the requirements, and by checking that done_o stays low on every handshake before the final one.

// File: rtl/pkt_merge_pkg.sv
package pkt_merge_pkg;
  localparam int WORD_W = 32;
  localparam int KEEP_W = WORD_W / 8;
  localparam int ID_W   = 5;
  localparam int TYPE_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_DRAIN
  } seq_st_e;
endpackage

// File: rtl/route_hdr_gen.sv
module route_hdr_gen
  import pkt_merge_pkg::*;
(
  input  logic [ID_W-1:0]   id_i,
  input  logic [TYPE_W-1:0] ptype_i,
  output logic [WORD_W-1:0] hdr_o
);
  logic [WORD_W-2:0] body;

  always_comb begin
    body        = '0;
    body[4:0]   = id_i;
    body[14:12] = ptype_i;
    body[20:16] = '1; // source row
    body[27:21] = '1; // source column
  end

  assign hdr_o = {~^body, body};
endmodule

// File: rtl/src_select.sv
module src_select
  import pkt_merge_pkg::*;
#(
  parameter int NUM_IN = 4,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic                     take_i,
  input  logic [NUM_IN*WORD_W-1:0] data_i,
  input  logic [NUM_IN*KEEP_W-1:0] keep_i,
  input  logic [NUM_IN-1:0]        valid_i,
  output logic [NUM_IN-1:0]        ready_o,
  output logic [WORD_W-1:0]        sel_data_o,
  output logic [KEEP_W-1:0]        sel_keep_o,
  output logic                     sel_valid_o
);
  logic [WORD_W-1:0] data_a [NUM_IN];
  logic [KEEP_W-1:0] keep_a [NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_src
    assign data_a[g]  = data_i[g*WORD_W +: WORD_W];
    assign keep_a[g]  = keep_i[g*KEEP_W +: KEEP_W];
    assign ready_o[g] = take_i && (sel_i == SEL_W'(g));
  end

  assign sel_data_o  = data_a[sel_i];
  assign sel_keep_o  = keep_a[sel_i];
  assign sel_valid_o = valid_i[sel_i];

  a_r8_ready_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ready_o));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pkt_merge_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int PKT_LEN = 8,
  parameter int CNT_W   = 16,
  localparam int SEL_W  = $clog2(NUM_IN),
  localparam int BEAT_W = $clog2(PKT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] iter_count_i,
  input  logic             adv_i,
  input  logic             out_ack_i,
  output seq_st_e          state_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             last_beat_o,
  output logic             done_o
);
  localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(NUM_IN - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PKT_LEN - 1);

  seq_st_e           st_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BEAT_W-1:0] beat_q;
  logic [CNT_W-1:0]  iter_q, total_q;
  logic              done_q;

  assign last_beat_o = (beat_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      beat_q  <= '0;
      iter_q  <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sel_q   <= '0;
          beat_q  <= '0;
          iter_q  <= '0;
          total_q <= iter_count_i;
          if (iter_count_i == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q <= 1'b0;
            st_q   <= ST_HDR;
          end
        end
        ST_HDR: if (adv_i) st_q <= ST_PAY;
        ST_PAY: if (adv_i) begin
          if (last_beat_o) begin
            beat_q <= '0;
            if (sel_q == LAST_SEL) begin
              sel_q <= '0;
              if (iter_q == total_q - 1'b1) begin
                st_q <= ST_DRAIN;
              end else begin
                iter_q <= iter_q + 1'b1;
                st_q   <= ST_HDR;
              end
            end else begin
              sel_q <= sel_q + 1'b1;
              st_q  <= ST_HDR;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_DRAIN: if (out_ack_i) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign sel_o   = sel_q;
  assign done_o  = done_q;

  a_r9_done_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> st_q == ST_IDLE);
  a_r9_zero_iter_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && iter_count_i == '0) |=> done_q);
  a_r6_next_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAY && adv_i && last_beat_o && sel_q != LAST_SEL) |=>
      (sel_q == $past(sel_q) + 1'b1 && st_q == ST_HDR));
  a_r6_wrap_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAY && adv_i && last_beat_o && sel_q == LAST_SEL) |=> sel_q == '0);
endmodule

// File: rtl/pkt_hdr_merge.sv
module pkt_hdr_merge
  import pkt_merge_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int PKT_LEN = 8,
  parameter int CNT_W   = 16,
  parameter logic [NUM_IN*ID_W-1:0] ID_TABLE = {5'd30, 5'd17, 5'd9, 5'd3},
  parameter logic [TYPE_W-1:0]      PKT_TYPE = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         iter_count_i,
  input  logic [NUM_IN*WORD_W-1:0] s_tdata_i,
  input  logic [NUM_IN*KEEP_W-1:0] s_tkeep_i,
  input  logic [NUM_IN-1:0]        s_tvalid_i,
  output logic [NUM_IN-1:0]        s_tready_o,
  output logic [WORD_W-1:0]        m_tdata_o,
  output logic [KEEP_W-1:0]        m_tkeep_o,
  output logic                     m_tlast_o,
  output logic                     m_tvalid_o,
  input  logic                     m_tready_i,
  output logic                     done_o
);
  localparam int SEL_W = $clog2(NUM_IN);

  seq_st_e           st;
  logic [SEL_W-1:0]  sel;
  logic              last_beat, slot_free, take, adv, out_ack, is_hdr;
  logic [WORD_W-1:0] sel_data, hdr;
  logic [KEEP_W-1:0] sel_keep;
  logic              sel_valid;
  logic [ID_W-1:0]   id_tab [NUM_IN];

  logic [WORD_W-1:0] data_q;
  logic [KEEP_W-1:0] keep_q;
  logic              last_q, valid_q, hdr_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_id
    assign id_tab[g] = ID_TABLE[g*ID_W +: ID_W];
  end

  assign slot_free = !valid_q || m_tready_i;
  assign is_hdr    = (st == ST_HDR);
  assign take      = (st == ST_PAY) && slot_free;
  assign adv       = (is_hdr && slot_free) || (take && sel_valid);
  assign out_ack   = valid_q && m_tready_i;

  seq_ctrl #(.NUM_IN(NUM_IN), .PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .iter_count_i,
    .adv_i(adv), .out_ack_i(out_ack),
    .state_o(st), .sel_o(sel), .last_beat_o(last_beat), .done_o
  );

  src_select #(.NUM_IN(NUM_IN)) i_sel (
    .clk_i, .rst_ni, .sel_i(sel), .take_i(take),
    .data_i(s_tdata_i), .keep_i(s_tkeep_i), .valid_i(s_tvalid_i),
    .ready_o(s_tready_o), .sel_data_o(sel_data), .sel_keep_o(sel_keep),
    .sel_valid_o(sel_valid)
  );

  route_hdr_gen i_hdr (.id_i(id_tab[sel]), .ptype_i(PKT_TYPE), .hdr_o(hdr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      keep_q  <= '0;
      last_q  <= 1'b0;
      valid_q <= 1'b0;
      hdr_q   <= 1'b0;
    end else if (adv) begin
      data_q  <= is_hdr ? hdr : sel_data;
      keep_q  <= is_hdr ? '1 : sel_keep;
      last_q  <= !is_hdr && last_beat;
      valid_q <= 1'b1;
      hdr_q   <= is_hdr;
    end else if (m_tready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign m_tdata_o  = data_q;
  assign m_tkeep_o  = keep_q;
  assign m_tlast_o  = last_q;
  assign m_tvalid_o = valid_q;

  a_r8_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=>
      (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tkeep_o) && $stable(m_tlast_o)));
  a_r8_no_take_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |-> s_tready_o == '0);
  a_r4_odd_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && hdr_q) |-> ^m_tdata_o);
  a_r7_hdr_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && hdr_q) |-> (!m_tlast_o && m_tkeep_o == '1));
  a_r3_hdr_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && hdr_q) |-> (m_tdata_o[27:16] == 12'hFFF && m_tdata_o[30:28] == 3'b0));
endmodule

// File: tb/test_pkt_hdr_merge.sv
module test_pkt_hdr_merge;
  localparam int N = 4;
  localparam int PW = N * 9;
  localparam logic [19:0] IDS = {5'd30, 5'd17, 5'd9, 5'd3};
  // {iterations[7:0], gap_mode[3:0], ready_mode[3:0]}
  localparam logic [15:0] TBL [6] = '{16'h0100, 16'h0201, 16'h0312, 16'h0102, 16'h0411, 16'h0210};

  logic clk = 0, rst_n = 0, start = 0, m_tready = 1;
  logic [15:0] iters = 0;
  logic [N*32-1:0] s_tdata;
  logic [N*4-1:0] s_tkeep;
  logic [N-1:0] s_tvalid, s_tready;
  logic [31:0] m_tdata;
  logic [3:0] m_tkeep;
  logic m_tlast, m_tvalid, done;

  int checks = 0, errors = 0;
  int cyc = 0, cnt [N];
  logic src_clr = 0, cap_clr = 0, gap = 0;
  int rdy_mode = 0;
  logic [36:0] cap [512];
  int wcnt = 0;
  logic early = 0;

  always #5 clk = ~clk;

  pkt_hdr_merge #(.ID_TABLE(IDS)) i_pkt_hdr_merge (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .iter_count_i(iters),
    .s_tdata_i(s_tdata), .s_tkeep_i(s_tkeep), .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
    .m_tdata_o(m_tdata), .m_tkeep_o(m_tkeep), .m_tlast_o(m_tlast), .m_tvalid_o(m_tvalid),
    .m_tready_i(m_tready), .done_o(done)
  );

  function automatic logic [31:0] src_word(int i, int n);
    return {4'hA, 4'(i), 8'h5C, 16'(n)};
  endfunction
  function automatic logic [3:0] src_keep(int n);
    return (n % 4 == 1) ? 4'h3 : 4'hF;
  endfunction
  function automatic logic [31:0] exp_hdr(int p);
    logic [31:0] h = '0;
    h[4:0] = IDS[p*5 +: 5];
    h[20:16] = 5'h1F;
    h[27:21] = 7'h7F;
    h[31] = ($countones(h[30:0]) % 2 == 0);
    return h;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_src
    assign s_tdata[g*32 +: 32] = src_word(g, cnt[g]);
    assign s_tkeep[g*4 +: 4] = src_keep(cnt[g]);
    assign s_tvalid[g] = gap ? ((cnt[g] + cyc + g) % 3 != 0) : 1'b1;
    always @(posedge clk)
      if (src_clr) cnt[g] <= 0;
      else if (s_tvalid[g] && s_tready[g]) cnt[g] <= cnt[g] + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: m_tready = 1'b1;
      1: m_tready = (cyc % 4) != 3;
      2: m_tready = cyc[0];
      default: m_tready = 1'b0;
    endcase
  end

  always @(negedge clk)
    if (cap_clr) begin
      wcnt = 0;
      early = 0;
    end else if (m_tvalid && m_tready) begin
      if (wcnt < 512) cap[wcnt] = {m_tlast, m_tkeep, m_tdata};
      wcnt++;
      if (done) early = 1;
    end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(int n, bit g, int rm);
    @(posedge clk); #2;
    src_clr = 1; cap_clr = 1; gap = g; rdy_mode = rm; iters = 16'(n);
    @(posedge clk); #2;
    src_clr = 0; cap_clr = 0; start = 1;
    @(posedge clk); #2;
    start = 0;
  endtask

  task automatic finish_and_compare(int n);
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R9 done after run", 64'(done), 64'd1);
    chk(!early, "R9 done not before last word", 64'(early), 64'd0);
    chk(wcnt == n * PW, "R6 word count", 64'(wcnt), 64'(n * PW));
    for (int w = 0; w < wcnt && w < n * PW; w++) begin
      int k = w / PW, p = (w % PW) / 9, b = (w % PW) % 9;
      logic [31:0] d = cap[w][31:0];
      if (b == 0) begin
        logic [31:0] h = exp_hdr(p);
        chk(d[11:0] == h[11:0], "R1 id field", 64'(d), 64'(h));
        chk(d[15:12] == 4'h0, "R2 type field", 64'(d), 64'(h));
        chk(d[30:16] == h[30:16], "R3 fixed fields", 64'(d), 64'(h));
        chk(d[31] == h[31], "R4 parity", 64'(d), 64'(h));
        chk(cap[w][36:32] == 5'h0F, "R7 header keep/last", 64'(cap[w][36:32]), 64'h0F);
      end else begin
        int m = k * 8 + b - 1;
        chk(d == src_word(p, m) && cap[w][35:32] == src_keep(m), "R5 payload",
            64'(cap[w][35:0]), 64'({src_keep(m), src_word(p, m)}));
        chk(cap[w][36] == (b == 8), "R7 payload last", 64'(cap[w][36]), 64'(b == 8));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_tvalid && s_tready == 0 && !done, "R10 reset state",
        64'({m_tvalid, s_tready, done}), 64'd0);
    rst_n = 1;

    for (int r = 0; r < 6; r++) begin
      launch(int'(TBL[r][15:8]), TBL[r][4], int'(TBL[r][3:0]));
      @(negedge clk);
      if (r > 0) chk(!done, "R9 start clears done", 64'(done), 64'd0);
      finish_and_compare(int'(TBL[r][15:8]));
    end

    // zero iterations
    launch(0, 0, 0);
    @(negedge clk);
    chk(done, "R9 zero iterations done", 64'(done), 64'd1);
    repeat (5) @(negedge clk);
    chk(wcnt == 0 && !m_tvalid, "R9 zero iterations no words", 64'(wcnt), 64'd0);

    // stall with ready held low
    launch(1, 0, 3);
    repeat (6) @(negedge clk);
    chk(m_tvalid && m_tdata == exp_hdr(0), "R8 stalled header presented", 64'(m_tdata), 64'(exp_hdr(0)));
    chk(s_tready == 0, "R8 no source read while full", 64'(s_tready), 64'd0);
    @(negedge clk);
    chk(m_tvalid && m_tdata == exp_hdr(0) && m_tkeep == 4'hF && !m_tlast, "R8 held word",
        64'(m_tdata), 64'(exp_hdr(0)));
    chk(cnt[0] == 0, "R8 source 0 untouched", 64'(cnt[0]), 64'd0);
    rdy_mode = 0;
    finish_and_compare(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule